// File: doc/BRIEF.md
# Gated Serial Management Clock Generator

This block derives a serial-management clock for one channel from a 100 MHz synchronous reference. In its default state it produces a slow clock of reference/100 (1 MHz) with equal high and low halves. While a synchronous fast-mode request is held, the output passes the reference itself (100 MHz) for the operations that need it. The output is clean in both directions of the change, because each change is made only while the output is low.

During power-up the output must never run faster than rated while upstream PLLs lock. The output is therefore forced low whenever power-good is low or the active-low reset is asserted. It stays low until a fixed number of reference cycles after reset rises. A reset synchronizer and a cleared divider make the position of the first rising edge after reset repeatable. A status output reports which rate is active, and it updates at the switch point.

Top module: `serclk_gen`

## Requirements
- R1: `sclk` is low, in both phases of `clk_ref`, whenever `pwr_good` is low or `rst_n` is low, whatever the value of `fast_req`. It goes low without waiting for a clock edge.
- R2: With `fast_req` low, `sclk` first rises on the 52nd rising edge of `clk_ref` after `rst_n` rises. That count is two synchronizer stages plus a half period of 50. `sclk` stays low before that edge.
- R3: In slow mode `sclk` has a period of 100 reference cycles. It is high for 50 consecutive rising-edge samples and then low for 50.
- R4: In fast mode `sclk` is high during every high phase of `clk_ref` and low during every low phase. Pulses begin with the reference high phase that follows the switch edge.
- R5: A fast request seen while the slow output is high does not shorten that high phase. The switch happens on the first rising edge at which the slow output was already low.
- R6: When `fast_req` is sampled low in fast mode, the reference high phase that follows that edge is still passed through complete. After that, `sclk` stays low until 50 rising edges have passed from the switch edge, and then it rises.
- R7: `fast_active` is 1 from the switch edge into fast mode until the switch edge back to slow mode. It is 0 in slow mode and during reset.
- R8: Asserting `rst_n` low in fast mode forces `sclk` and `fast_active` low at once, during a reference high phase, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | 100 MHz synchronous reference clock |
| pwr_good | input | 1 | Power-good; low holds the block in reset |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| fast_req | input | 1 | Request for full reference rate, synchronous to `clk_ref` |
| sclk | output | 1 | Serial-management clock output |
| fast_active | output | 1 | 1 while the full-rate mode is in effect |

## Verification
The assertions assume that `fast_req` is synchronous to `clk_ref` and never changes near a rising edge. They also assume that `pwr_good` and `rst_n` reach the block only through its own synchronizer, so the internal state is either held cleared or runs on clean edges. The stimulus drives every input shortly after a falling reference edge. It samples `sclk` a little after each rising edge to see the high phase, and a little after each falling edge to see the low phase. The only input changes made inside a high phase are the deliberate reset and power-good drops that test the asynchronous forcing low.

// File: rtl/serclk_pkg.sv
package serclk_pkg;

  typedef enum logic {
    RATE_SLOW = 1'b0,
    RATE_FAST = 1'b1
  } rate_mode_e;

endpackage

// File: rtl/serclk_rst_sync.sv
module serclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] chain_d;

  always_comb begin
    chain_d = {chain_q[LAST-1:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_no = chain_q[LAST];

endmodule

// File: rtl/serclk_div.sv
module serclk_div #(
  parameter int DIV_RATIO = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hold_i,
  output logic slow_o
);

  localparam int HALF = DIV_RATIO / 2;
  localparam int CW   = $clog2(DIV_RATIO);
  localparam logic [CW-1:0] TOP_CNT  = CW'(DIV_RATIO - 1);
  localparam logic [CW-1:0] HALF_CNT = CW'(HALF);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          slow_q, slow_d;

  always_comb begin
    if (hold_i) begin
      cnt_d  = '0;
      slow_d = 1'b0;
    end else begin
      cnt_d  = (cnt_q == TOP_CNT) ? '0 : cnt_q + 1'b1;
      slow_d = (cnt_d >= HALF_CNT);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      slow_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      slow_q <= slow_d;
    end
  end

  assign slow_o = slow_q;

  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TOP_CNT);

  // R3
  rise_at_half_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(slow_q) |-> cnt_q == HALF_CNT);

  // R3
  fall_at_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(slow_q) |-> cnt_q == '0);

endmodule

// File: rtl/serclk_mode_ctrl.sv
module serclk_mode_ctrl
  import serclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fast_req_i,
  input  logic slow_i,
  output logic hold_o,
  output logic gate_o,
  output logic fast_o
);

  rate_mode_e mode_q, mode_d;
  logic       gate_q;

  always_comb begin
    mode_d = mode_q;
    unique case (mode_q)
      RATE_SLOW: if (fast_req_i && !slow_i) mode_d = RATE_FAST;
      RATE_FAST: if (!fast_req_i)           mode_d = RATE_SLOW;
      default:                              mode_d = RATE_SLOW;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= RATE_SLOW;
    end else begin
      mode_q <= mode_d;
    end
  end

  // gate enable changes only while the reference is low
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= (mode_q == RATE_FAST);
    end
  end

  assign hold_o = (mode_q == RATE_FAST) || (mode_d == RATE_FAST);
  assign gate_o = gate_q;
  assign fast_o = (mode_q == RATE_FAST);

  // R5
  enter_when_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fast_o) |-> !$past(slow_i));

  // R4
  slow_quiet_in_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_o |-> !slow_i);

  // R6
  leave_on_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fast_o) |-> !$past(fast_req_i));

endmodule

// File: rtl/serclk_gen.sv
module serclk_gen
  import serclk_pkg::*;
#(
  parameter int DIV_RATIO   = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic pwr_good,
  input  logic rst_n,
  input  logic fast_req,
  output logic sclk,
  output logic fast_active
);

  logic arst_n;
  logic run_n;
  logic hold;
  logic slow_lvl;
  logic gate_en;

  assign arst_n = rst_n & pwr_good;

  serclk_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) rst_sync_i (
    .clk_i   (clk_ref),
    .arst_ni (arst_n),
    .rst_no  (run_n)
  );

  serclk_div #(
    .DIV_RATIO (DIV_RATIO)
  ) div_i (
    .clk_i  (clk_ref),
    .rst_ni (run_n),
    .hold_i (hold),
    .slow_o (slow_lvl)
  );

  serclk_mode_ctrl mode_i (
    .clk_i      (clk_ref),
    .rst_ni     (run_n),
    .fast_req_i (fast_req),
    .slow_i     (slow_lvl),
    .hold_o     (hold),
    .gate_o     (gate_en),
    .fast_o     (fast_active)
  );

  assign sclk = slow_lvl | (gate_en & clk_ref);

  // R1
  always @(negedge clk_ref) begin
    if (!arst_n) begin
      held_low_chk: assert (!sclk && !fast_active);
    end
  end

endmodule

// File: tb/serclk_gen_tb_top.sv
module serclk_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  typedef struct packed {
    logic       req;
    logic [7:0] cyc;
    logic       hi;
    logic       lo;
    logic       fast;
    logic [3:0] rid;
  } vec_t;

  // req, posedges to advance, sclk in high phase, sclk in low phase, fast_active, requirement
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 8'd51, 1'b0, 1'b0, 1'b0, 4'd2},
    '{1'b0, 8'd1,  1'b1, 1'b1, 1'b0, 4'd2},
    '{1'b0, 8'd49, 1'b1, 1'b1, 1'b0, 4'd3},
    '{1'b0, 8'd1,  1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b0, 8'd49, 1'b0, 1'b0, 1'b0, 4'd3},
    '{1'b0, 8'd1,  1'b1, 1'b1, 1'b0, 4'd3},
    '{1'b1, 8'd1,  1'b1, 1'b1, 1'b0, 4'd5},
    '{1'b1, 8'd48, 1'b1, 1'b1, 1'b0, 4'd5},
    '{1'b1, 8'd1,  1'b0, 1'b0, 1'b0, 4'd5},
    '{1'b1, 8'd1,  1'b0, 1'b0, 1'b1, 4'd7},
    '{1'b1, 8'd1,  1'b1, 1'b0, 1'b1, 4'd4},
    '{1'b1, 8'd5,  1'b1, 1'b0, 1'b1, 4'd4},
    '{1'b0, 8'd1,  1'b1, 1'b0, 1'b0, 4'd6},
    '{1'b0, 8'd1,  1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b0, 8'd48, 1'b0, 1'b0, 1'b0, 4'd6},
    '{1'b0, 8'd1,  1'b1, 1'b1, 1'b0, 4'd6}
  };

  logic clk_ref = 1'b0;
  logic pwr_good, rst_n, fast_req;
  logic sclk, fast_active;
  int   n_tests = 0;
  int   n_failed = 0;

  always #(CLK_PERIOD / 2) clk_ref = ~clk_ref;

  serclk_gen dut_i (
    .clk_ref     (clk_ref),
    .pwr_good    (pwr_good),
    .rst_n       (rst_n),
    .fast_req    (fast_req),
    .sclk        (sclk),
    .fast_active (fast_active)
  );

  function automatic string rname(input logic [3:0] id);
    case (id)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      4'd6:    return "R6";
      4'd7:    return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_failed++;
      $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_failed++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
    $finish;
  end

  initial begin
    pwr_good = 1'b0;
    rst_n    = 1'b0;
    fast_req = 1'b1;

    // R1 / R7: everything low before power-good, even with a fast request
    repeat (3) @(negedge clk_ref);
    #2;
    check("R1", "sclk low phase, no power", sclk, 1'b0);
    check("R7", "fast_active in reset", fast_active, 1'b0);
    @(posedge clk_ref); #2;
    check("R1", "sclk high phase, no power", sclk, 1'b0);

    // R1: power good, reset still low
    @(negedge clk_ref); #2;
    pwr_good = 1'b1;
    repeat (3) @(posedge clk_ref);
    #2;
    check("R1", "sclk high phase, reset held", sclk, 1'b0);

    // release at a falling edge; P1 is the next rising edge
    @(negedge clk_ref); #2;
    fast_req = 1'b0;
    rst_n    = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      fast_req = VECS[i].req;
      repeat (int'(VECS[i].cyc)) @(posedge clk_ref);
      #2;
      check(rname(VECS[i].rid), $sformatf("vec %0d sclk high phase", i), sclk, VECS[i].hi);
      check(rname(VECS[i].rid), $sformatf("vec %0d fast_active", i), fast_active, VECS[i].fast);
      @(negedge clk_ref); #2;
      check(rname(VECS[i].rid), $sformatf("vec %0d sclk low phase", i), sclk, VECS[i].lo);
    end

    // R8: enter fast mode, then drop reset inside a high phase
    fast_req = 1'b1;
    for (int k = 0; k < 200 && !fast_active; k++) begin
      @(posedge clk_ref); #2;
    end
    check("R5", "fast mode reached", fast_active, 1'b1);
    @(posedge clk_ref); #2;
    check("R4", "fast pulse before reset", sclk, 1'b1);
    rst_n = 1'b0;
    #1;
    check("R8", "sclk forced low at once", sclk, 1'b0);
    check("R8", "fast_active cleared at once", fast_active, 1'b0);

    // release with the request held: switch on the first running edge (P3)
    @(negedge clk_ref); #2;
    rst_n = 1'b1;
    repeat (2) @(posedge clk_ref);
    #2;
    check("R7", "fast_active before first running edge", fast_active, 1'b0);
    @(posedge clk_ref); #2;
    check("R7", "fast_active at first running edge", fast_active, 1'b1);
    check("R4", "no pulse on switch edge", sclk, 1'b0);
    @(posedge clk_ref); #2;
    check("R4", "pulse after switch edge", sclk, 1'b1);

    // R1: power-good drop inside a high phase
    pwr_good = 1'b0;
    #1;
    check("R1", "sclk low after power loss", sclk, 1'b0);
    check("R1", "fast_active low after power loss", fast_active, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_failed);
    $finish;
  end

endmodule